// File: doc/BRIEF.md
# SMT Commit Thread Selector

In a core that runs several hardware threads through one out-of-order pipeline, each thread has its own reorder-buffer partition. This block decides which of those threads may retire its oldest entry next. The retire logic raises an ask strobe for each commit slot it wants to fill. The selector answers with a valid flag and a thread number. The answer is registered, so it appears on the clock edge after the ask.

For each thread, the selector reads a 3-bit status code, a head-ready flag, a buffer-empty flag and the sequence number of the oldest entry. A 2-bit policy input picks one of three arbitration rules:

- **Greedy:** same selection as oldest-first.
- **Rotating:** a priority list where each winner moves to the back.
- **Oldest-first:** the smallest head sequence number wins.

The only state the block keeps is the rotating priority list. Retirement and status updates happen elsewhere.

Top module: `smt_commit_sel`

## Requirements
- R1: After synchronous reset, sel_valid is 0 and the rotating priority list holds the threads in order 0, 1, ..., N-1 from the front.
- R2: A thread can be selected only when its status code is 0 (running), 1 (idle) or 4 (waiting on a fetch-side trap). Codes 2, 3, 5, 6 and 7 make it ineligible under every policy.
- R3: With policy 1 (rotating), the result is the first thread in priority-list order that is eligible and has head_rdy set. The empty flag is not considered.
- R4: Each grant under policy 1 removes the winner from its place in the list and appends it at the back. The other threads keep their relative order. Several grants in successive asks rotate the list several times.
- R5: With policy 2 (oldest-first), a candidate must be eligible, have head_rdy set and have rob_empty clear. The candidate with the smallest head_seq wins.
- R6: Under oldest-first, equal head_seq values are resolved in favour of the lower thread number.
- R7: Policy 0 (greedy) gives exactly the same result as policy 2.
- R8: When no thread qualifies under the active policy, sel_valid is 0.
- R9: When NUM_THREADS is 1, the policy input is ignored. Thread 0 is returned when its status is eligible, whatever its ready and empty flags are. Otherwise no thread is returned.
- R10: A cycle with ask low produces sel_valid 0 on the next edge and leaves the priority list unchanged.
- R11: Policy 3 is reserved. It never grants and never changes the priority list.
- R12: Results are registered: sel_valid and sel_tid reflect the inputs present at the clock edge that follows the ask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ask | input | 1 | Request one selection for this commit slot |
| policy | input | 2 | 0 greedy, 1 rotating, 2 oldest-first, 3 reserved |
| thr_state | input | 3*NUM_THREADS | Per-thread status code; thread k in bits [3k+2:3k] |
| head_rdy | input | NUM_THREADS | Per-thread head entry ready to retire |
| rob_empty | input | NUM_THREADS | Per-thread reorder-buffer partition empty |
| head_seq | input | SEQ_W*NUM_THREADS | Per-thread head sequence number; thread k in bits [SEQ_W*k +: SEQ_W] |
| sel_valid | output | 1 | A thread was selected for the previous ask |
| sel_tid | output | max(1,clog2(NUM_THREADS)) | Selected thread number |

## Verification
The rotating policy is first driven with all threads ready. This shows whether the list resets in order and whether a winner moves to the back, not to a fixed rotation point. Sparse ready patterns and mixed status codes then separate "first ready in list order" from "lowest thread number" and expose any status code that is treated wrongly.

Oldest-first and greedy are driven with narrow sequence ranges, so that ties and empty-but-ready threads are frequent. Stretches with ask dropped and with the reserved policy, each followed by rotating asks, show whether the list moved when it should not have.

A single-thread instance runs beside the main instance to cover the bypass path.

// File: rtl/smt_sel_pkg.sv
package smt_sel_pkg;
  typedef enum logic [2:0] {
    TS_RUN    = 3'd0,
    TS_IDLE   = 3'd1,
    TS_SQUASH = 3'd2,
    TS_TRAP   = 3'd3,
    TS_FTRAP  = 3'd4,
    TS_HALT   = 3'd5,
    TS_RSV6   = 3'd6,
    TS_RSV7   = 3'd7
  } tstate_e;

  typedef enum logic [1:0] {
    POL_GREEDY = 2'd0,
    POL_ROTATE = 2'd1,
    POL_OLDEST = 2'd2,
    POL_RSV    = 2'd3
  } policy_e;

  function automatic logic state_ok(input logic [2:0] s);
    return (s == TS_RUN) || (s == TS_IDLE) || (s == TS_FTRAP);
  endfunction
endpackage

// File: rtl/smt_elig.sv
module smt_elig #(
  parameter int NUM_THREADS = 4
) (
  input  logic [3*NUM_THREADS-1:0] thr_state,
  output logic [NUM_THREADS-1:0]   ok
);
  import smt_sel_pkg::*;

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
    assign ok[g] = state_ok(thr_state[3*g +: 3]);
  end
endmodule

// File: rtl/smt_rr_list.sv
module smt_rr_list #(
  parameter int NUM_THREADS = 4,
  localparam int IDW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_THREADS-1:0] cand,
  input  logic                   adv,
  output logic                   found,
  output logic [IDW-1:0]         pick
);
  logic [IDW-1:0] prio_q [NUM_THREADS];
  logic [IDW-1:0] pos;
  logic [NUM_THREADS-1:0] seen;

  always_comb begin
    found = 1'b0;
    pos   = '0;
    pick  = '0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      if (!found && cand[prio_q[k]]) begin
        found = 1'b1;
        pos   = IDW'(k);
        pick  = prio_q[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_THREADS; k++) prio_q[k] <= IDW'(k);
    end else if (adv && found) begin
      for (int k = 0; k < NUM_THREADS-1; k++) begin
        if (IDW'(k) >= pos) prio_q[k] <= prio_q[k+1];
      end
      prio_q[NUM_THREADS-1] <= pick;
    end
  end

  always_comb begin
    seen = '0;
    for (int k = 0; k < NUM_THREADS; k++) seen[prio_q[k]] = 1'b1;
  end

  // R4: the list always holds every thread exactly once
  p_list_perm_r4: assert property (@(posedge clk) disable iff (rst) &seen);
  // R4: a granted thread lands at the back of the list
  p_winner_back_r4: assert property (@(posedge clk) disable iff (rst)
    (adv && found) |=> (prio_q[NUM_THREADS-1] == $past(pick)));
  // R10/R11: without an advance, the list holds still
  p_list_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !adv |=> (prio_q[0] == $past(prio_q[0])));
endmodule

// File: rtl/smt_oldest_pick.sv
module smt_oldest_pick #(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W = 16,
  localparam int IDW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic [NUM_THREADS-1:0]       cand,
  input  logic [SEQ_W*NUM_THREADS-1:0] head_seq,
  output logic                         found,
  output logic [IDW-1:0]               pick
);
  logic [SEQ_W-1:0] best;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    best  = '0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      // strict compare keeps the lower thread on equal sequence numbers
      if (cand[k] && (!found || head_seq[SEQ_W*k +: SEQ_W] < best)) begin
        found = 1'b1;
        pick  = IDW'(k);
        best  = head_seq[SEQ_W*k +: SEQ_W];
      end
    end
  end

  // R5: a reported pick is always one of the candidates
  always_comb begin
    if (found) p_pick_is_cand_r5: assert (cand[pick]);
  end
endmodule

// File: rtl/smt_commit_sel.sv
module smt_commit_sel #(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W = 16,
  localparam int IDW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ask,
  input  logic [1:0]                   policy,
  input  logic [3*NUM_THREADS-1:0]     thr_state,
  input  logic [NUM_THREADS-1:0]       head_rdy,
  input  logic [NUM_THREADS-1:0]       rob_empty,
  input  logic [SEQ_W*NUM_THREADS-1:0] head_seq,
  output logic                         sel_valid,
  output logic [IDW-1:0]               sel_tid
);
  import smt_sel_pkg::*;

  logic [NUM_THREADS-1:0] ok;
  logic [NUM_THREADS-1:0] ok_prev;
  logic                   found;
  logic [IDW-1:0]         pick;

  smt_elig #(.NUM_THREADS(NUM_THREADS)) elig_i (
    .thr_state(thr_state),
    .ok       (ok)
  );

  if (NUM_THREADS == 1) begin : g_single
    // policy bypassed: eligible status alone decides
    assign found = ok[0];
    assign pick  = '0;
  end else begin : g_multi
    logic           rr_found, old_found;
    logic [IDW-1:0] rr_pick, old_pick;

    smt_rr_list #(.NUM_THREADS(NUM_THREADS)) rr_i (
      .clk  (clk),
      .rst  (rst),
      .cand (ok & head_rdy),
      .adv  (ask && (policy == POL_ROTATE)),
      .found(rr_found),
      .pick (rr_pick)
    );

    smt_oldest_pick #(.NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W)) old_i (
      .cand    (ok & head_rdy & ~rob_empty),
      .head_seq(head_seq),
      .found   (old_found),
      .pick    (old_pick)
    );

    always_comb begin
      unique case (policy)
        POL_ROTATE: begin found = rr_found;  pick = rr_pick;  end
        POL_GREEDY,
        POL_OLDEST: begin found = old_found; pick = old_pick; end
        default:    begin found = 1'b0;      pick = '0;       end
      endcase
    end

    // R11: the reserved policy never grants
    p_rsv_none_r11: assert property (@(posedge clk) disable iff (rst)
      (ask && policy == POL_RSV) |=> !sel_valid);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid <= 1'b0;
      sel_tid   <= '0;
      ok_prev   <= '0;
    end else begin
      sel_valid <= ask && found;
      if (ask && found) sel_tid <= pick;
      ok_prev   <= ok;
    end
  end

  // R10: no ask, no result
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !ask |=> !sel_valid);
  // R2: a granted thread had an eligible status when asked
  p_elig_r2: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> ok_prev[sel_tid]);
  // R8: nobody eligible means no grant
  p_none_r8: assert property (@(posedge clk) disable iff (rst)
    (ask && ok == '0) |=> !sel_valid);
endmodule

// File: tb/smt_commit_sel_tb.sv
module smt_commit_sel_tb_top;
  localparam int N = 4;
  localparam int SW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ask = 1'b0;
  logic [1:0] policy = 2'd0;
  logic [3*N-1:0] thr_state = '0;
  logic [N-1:0] head_rdy = '0, rob_empty = '0;
  logic [SW*N-1:0] head_seq = '0;
  logic sel_valid;
  logic [1:0] sel_tid;
  logic sel1_valid;
  logic sel1_tid;

  always #4 clk = ~clk;

  smt_commit_sel #(.NUM_THREADS(N), .SEQ_W(SW)) dut_i (
    .clk(clk), .rst(rst), .ask(ask), .policy(policy),
    .thr_state(thr_state), .head_rdy(head_rdy), .rob_empty(rob_empty),
    .head_seq(head_seq), .sel_valid(sel_valid), .sel_tid(sel_tid));

  smt_commit_sel #(.NUM_THREADS(1), .SEQ_W(SW)) dut1_i (
    .clk(clk), .rst(rst), .ask(ask), .policy(policy),
    .thr_state(thr_state[2:0]), .head_rdy(head_rdy[0:0]),
    .rob_empty(rob_empty[0:0]), .head_seq(head_seq[SW-1:0]),
    .sel_valid(sel1_valid), .sel_tid(sel1_tid));

  int checks = 0, bad = 0;
  int prio[$];
  int st[N], sq[N];
  bit rdy[N], emp[N];
  bit exp_v, exp1_v;
  int exp_t;
  bit done = 0;

  function automatic bit elig(int s);
    return s == 0 || s == 1 || s == 4;
  endfunction

  task automatic check(string tag, bit ok, int av, int at, int ev, int et);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got valid=%0d tid=%0d expected valid=%0d tid=%0d",
               tag, av, at, ev, et);
    end
  endtask

  // drive current stimulus arrays, compute expectations, advance model
  task automatic step(string tag);
    int pos;
    for (int k = 0; k < N; k++) begin
      thr_state[3*k +: 3] = 3'(st[k]);
      head_rdy[k] = rdy[k];
      rob_empty[k] = emp[k];
      head_seq[SW*k +: SW] = SW'(sq[k]);
    end
    exp_v = 0; exp_t = 0; pos = 0;
    if (ask) begin
      if (policy == 2'd1) begin
        foreach (prio[k]) begin
          if (!exp_v && elig(st[prio[k]]) && rdy[prio[k]]) begin
            exp_v = 1; exp_t = prio[k]; pos = k;
          end
        end
        if (exp_v) begin
          prio.delete(pos);
          prio.push_back(exp_t);
        end
      end else if (policy != 2'd3) begin
        for (int k = 0; k < N; k++) begin
          if (elig(st[k]) && rdy[k] && !emp[k] && (!exp_v || sq[k] < sq[exp_t])) begin
            exp_v = 1; exp_t = k;
          end
        end
      end
    end
    exp1_v = ask && elig(st[0]);
    @(negedge clk);
    check(tag, sel_valid == exp_v && (!exp_v || sel_tid == 2'(exp_t)),
          sel_valid, sel_tid, exp_v, exp_t);
    check("R9 single", sel1_valid == exp1_v && (!exp1_v || sel1_tid == 1'b0),
          sel1_valid, sel1_tid, exp1_v, 0);
  endtask

  task automatic rand_in(int st_mode, int seq_max);
    for (int k = 0; k < N; k++) begin
      case (st_mode)
        0: st[k] = 0;
        1: st[k] = $urandom_range(7);
        2: st[k] = ($urandom_range(1) == 1) ? 2 : 3;
        default: st[k] = ($urandom_range(2) == 0) ? 5 : (($urandom_range(1) == 1) ? 4 : 1);
      endcase
      rdy[k] = $urandom_range(1) == 1;
      emp[k] = $urandom_range(3) == 0;
      sq[k]  = $urandom_range(seq_max);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) prio.push_back(k);
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset", sel_valid == 0 && sel1_valid == 0, sel_valid, sel_tid, 0, 0);
    // R1 R4: all ready under rotation yields 0,1,2,3,0,...
    ask = 1; policy = 2'd1;
    for (int k = 0; k < N; k++) begin st[k] = 0; rdy[k] = 1; emp[k] = 0; sq[k] = k; end
    repeat (9) step("R1 R4 rotate order");
    // R3: sparse ready
    repeat (30) begin rand_in(0, 7); step("R3 rotate sparse"); end
    // R2: mixed status codes
    repeat (40) begin rand_in(1, 7); step("R2 status filter"); end
    repeat (20) begin rand_in(3, 7); step("R2 status filter"); end
    // R5: oldest-first
    policy = 2'd2;
    repeat (40) begin rand_in(1, 1000); step("R5 oldest"); end
    // R6: ties
    repeat (30) begin rand_in(0, 1); step("R6 tie low id"); end
    // R7: greedy
    policy = 2'd0;
    repeat (40) begin rand_in(0, 3); step("R7 greedy"); end
    // R8: nobody eligible
    for (int p = 0; p < 4; p++) begin
      policy = 2'(p);
      repeat (5) begin rand_in(2, 7); step("R8 none"); end
    end
    // R10: ask dropped, then rotation reveals list
    policy = 2'd1;
    repeat (30) begin rand_in(0, 7); ask = $urandom_range(1) == 1; step("R10 no ask"); end
    ask = 1;
    repeat (8) begin rand_in(0, 7); for (int k = 0; k < N; k++) rdy[k] = 1; step("R10 list kept"); end
    // R11: reserved policy
    policy = 2'd3;
    repeat (10) begin rand_in(0, 7); step("R11 reserved"); end
    policy = 2'd1;
    repeat (8) begin rand_in(0, 7); for (int k = 0; k < N; k++) rdy[k] = 1; step("R11 list kept"); end
    // R12: mixed traffic, results one edge after the ask
    repeat (300) begin
      policy = 2'($urandom_range(3));
      ask = $urandom_range(3) != 0;
      rand_in($urandom_range(1), 5);
      step("R12 mixed");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule